// File: doc/BRIEF.md
# Block-Atomic Register Commit Buffer

This unit sits between an array of execution units and the architectural register file. Instructions are grouped into blocks. Each block declares, when it is dispatched, how many register outputs it will produce. Those outputs arrive in any order from the execution array and are held in a per-block buffer. They are not written to the register file while the block is still running. Once the last expected output has arrived, the block counts as complete. Its buffered values are then copied into the register file one write per cycle, in the order in which they arrived.

Two blocks can be in flight at once: the oldest one and one younger block launched on a prediction. A register lookup port serves instructions of the younger block. It returns the newest pending value for a register, searching the younger block first, then the older one, and otherwise passing through the register file's own read data.

On a misprediction or an exception, a flush throws away every block that has not yet completed. If the oldest block is already complete, it counts as committed. It finishes its drain, and only the younger block is dropped.

Top module: `blk_commit_unit`

## Requirements
- R1: After reset no block is in flight: `disp_ready` is 1, `disp_slot` is 0, `rf_we` is 0 and `rd_hit` is 0.
- R2: `disp_slot` names the buffer that the next dispatch will fill. When nothing is in flight this is the current oldest position; otherwise it is the other buffer. `disp_ready` is 0 while both buffers hold a block, and a dispatch while `disp_ready` is 0 is dropped.
- R3: An output write is ignored in three cases: its `out_slot` (0 or 1) names a buffer that holds no block, the block is already complete, or the block already holds its declared count of outputs.
- R4: A block is complete in the cycle after its number of received outputs equals its declared count. A block declared with count 0 is complete right after dispatch, frees its buffer one cycle later, and makes no register file write.
- R5: From the first cycle in which the oldest block is complete, `rf_we` is 1 for exactly count consecutive cycles. Each of those cycles presents one buffered output (`rf_waddr`, `rf_wdata`), in arrival order, so a later write to the same register lands last.
- R6: The younger block makes no register file write until the oldest block has presented its last write. Its drain may start in the very next cycle.
- R7: A lookup of `rd_reg` returns `rd_hit`=1 and the newest buffered value from the younger block if that block holds the register; failing that, from the oldest block. If neither holds it, the result is `rd_hit`=0 with `rd_data` equal to `rf_rdata`.
- R8: A flush while the oldest block is incomplete empties both buffers by the next cycle. Writes and dispatch in the flush cycle are ignored, and the position of the oldest buffer is unchanged.
- R9: A flush while the oldest block is complete lets that block finish all of its register file writes and discards only the younger block.
- R10: `disp_count` ranges from 0 to NENT (16 by default). A block with NENT outputs is held in full and commits all NENT of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch a new block |
| disp_count | input | $clog2(NENT+1) | Number of outputs the new block will produce |
| disp_ready | output | 1 | A buffer is free for a dispatch |
| disp_slot | output | 1 | Buffer the next dispatch will occupy |
| out_valid | input | 1 | An output value arrives from the execution array |
| out_slot | input | 1 | Buffer of the block the output belongs to |
| out_reg | input | $clog2(NREG) | Destination register of the output |
| out_data | input | DATA_W | Output value |
| flush | input | 1 | Misprediction or exception recovery |
| rd_reg | input | $clog2(NREG) | Register looked up by the next block |
| rf_rdata | input | DATA_W | Register file read data for `rd_reg` |
| rd_hit | output | 1 | Lookup served from a buffered value |
| rd_data | output | DATA_W | Lookup result |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | $clog2(NREG) | Register file write address |
| rf_wdata | output | DATA_W | Register file write data |

## Verification
The assertions assume that `disp_count` never exceeds NENT while `disp_valid` is high; the bench draws counts from 0 to 4 plus occasional full blocks of 16, so it keeps to that range. Every other input is left unconstrained by the assertions. The random stimulus deliberately aims writes at empty, complete and full buffers, fires flushes at arbitrary moments including mid-drain, and dispatches while both buffers are busy. These cases exercise the rules that ignore such inputs, not assumptions that forbid them.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int unsigned SLOTS = 2;
  typedef logic slot_id_t;

  function automatic slot_id_t other_slot(slot_id_t s);
    return ~s;
  endfunction
endpackage

// File: rtl/bcu_slot.sv
module bcu_slot #(
  parameter int unsigned RW     = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NENT   = 16,
  localparam int unsigned EW    = $clog2(NENT),
  localparam int unsigned CW    = $clog2(NENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [CW-1:0]     alloc_cnt_i,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [RW-1:0]     wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [RW-1:0]     look_idx_i,
  output logic              look_hit_o,
  output logic [DATA_W-1:0] look_data_o,
  input  logic [EW-1:0]     drn_ptr_i,
  output logic [RW-1:0]     drn_idx_o,
  output logic [DATA_W-1:0] drn_data_o,
  output logic              valid_o,
  output logic              done_o,
  output logic [CW-1:0]     exp_o
);
  logic              valid_q, valid_d;
  logic [CW-1:0]     exp_q, exp_d;
  logic [CW-1:0]     arr_q, arr_d;
  logic [NENT-1:0]   ev_q, ev_d;
  logic [RW-1:0]     idx_q [NENT];
  logic [DATA_W-1:0] dat_q [NENT];
  logic              wr_take;

  assign wr_take = wr_en_i & valid_q & (arr_q < exp_q);

  always_comb begin
    valid_d = valid_q;
    exp_d   = exp_q;
    arr_d   = arr_q;
    ev_d    = ev_q;
    if (clear_i) begin
      valid_d = 1'b0;
      ev_d    = '0;
    end else if (alloc_i) begin
      valid_d = 1'b1;
      exp_d   = alloc_cnt_i;
      arr_d   = '0;
      ev_d    = '0;
    end else if (wr_take) begin
      arr_d = arr_q + CW'(1);
      ev_d[arr_q[EW-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      exp_q   <= '0;
      arr_q   <= '0;
      ev_q    <= '0;
    end else begin
      valid_q <= valid_d;
      exp_q   <= exp_d;
      arr_q   <= arr_d;
      ev_q    <= ev_d;
    end
  end

  // entry payload needs no reset: every use is qualified by ev_q
  always_ff @(posedge clk) begin
    if (wr_take && !clear_i && !alloc_i) begin
      idx_q[arr_q[EW-1:0]] <= wr_idx_i;
      dat_q[arr_q[EW-1:0]] <= wr_data_i;
    end
  end

  // newest matching entry wins: later entries override in loop order
  always_comb begin
    look_hit_o  = 1'b0;
    look_data_o = '0;
    for (int j = 0; j < int'(NENT); j++) begin
      if (ev_q[j] && idx_q[j] == look_idx_i) begin
        look_hit_o  = 1'b1;
        look_data_o = dat_q[j];
      end
    end
  end

  assign drn_idx_o  = idx_q[drn_ptr_i];
  assign drn_data_o = dat_q[drn_ptr_i];
  assign valid_o    = valid_q;
  assign done_o     = valid_q && (arr_q == exp_q);
  assign exp_o      = exp_q;

  AST_ARR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> arr_q <= exp_q); // R3
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wr_en_i && !alloc_i) |=> $stable(arr_q)); // R3
endmodule

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
  import bcu_pkg::*;
#(
  parameter int unsigned NENT = 16,
  localparam int unsigned EW  = $clog2(NENT),
  localparam int unsigned CW  = $clog2(NENT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    valid_i,
  input  logic [1:0]    done_i,
  input  logic [CW-1:0] exp0_i,
  input  logic [CW-1:0] exp1_i,
  input  logic          disp_v_i,
  input  logic          wr_v_i,
  input  logic          wr_slot_i,
  input  logic          flush_i,
  output logic          head_o,
  output logic [1:0]    alloc_o,
  output logic [1:0]    clear_o,
  output logic [1:0]    wr_en_o,
  output logic [EW-1:0] drn_ptr_o,
  output logic          rf_we_o,
  output logic          disp_ready_o,
  output logic          disp_slot_o
);
  slot_id_t      head_q, head_d, young, tail;
  logic [EW-1:0] dptr_q, dptr_d;
  logic [CW-1:0] exp_h;
  logic          head_done, retire;

  always_comb begin
    young     = other_slot(head_q);
    exp_h     = head_q ? exp1_i : exp0_i;
    head_done = done_i[head_q];
    retire    = head_done && ((exp_h == '0) || (CW'(dptr_q) + CW'(1) == exp_h));
    tail      = valid_i[head_q] ? young : head_q;

    clear_o = '0;
    if (flush_i) begin
      if (head_done) clear_o[young] = 1'b1;
      else           clear_o        = 2'b11;
    end
    if (retire) clear_o[head_q] = 1'b1;

    alloc_o = '0;
    if (disp_v_i && !valid_i[tail] && !flush_i) alloc_o[tail] = 1'b1;

    for (int s = 0; s < int'(SLOTS); s++) begin
      wr_en_o[s] = wr_v_i && !flush_i && (wr_slot_i == slot_id_t'(s));
    end

    head_d = head_q;
    dptr_d = dptr_q;
    if (retire) begin
      head_d = young;
      dptr_d = '0;
    end else if (head_done) begin
      dptr_d = dptr_q + EW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= 1'b0;
      dptr_q <= '0;
    end else begin
      head_q <= head_d;
      dptr_q <= dptr_d;
    end
  end

  assign head_o       = head_q;
  assign drn_ptr_o    = dptr_q;
  assign rf_we_o      = head_done && (exp_h != '0);
  assign disp_ready_o = !valid_i[tail];
  assign disp_slot_o  = tail;

  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && !retire) |=> (rf_we_o && dptr_q == $past(dptr_q) + EW'(1))); // R5
  AST_YOUNG_NEEDS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i[other_slot(head_q)] |-> valid_i[head_q]); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !head_done) |=> (valid_i == 2'b00)); // R8
  AST_FLUSH_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && head_done && !retire) |=> (valid_i[head_q] && !valid_i[other_slot(head_q)])); // R9
endmodule

// File: rtl/blk_commit_unit.sv
module blk_commit_unit
  import bcu_pkg::*;
#(
  parameter int unsigned NREG   = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NENT   = 16,
  localparam int unsigned RW    = $clog2(NREG),
  localparam int unsigned EW    = $clog2(NENT),
  localparam int unsigned CW    = $clog2(NENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic [CW-1:0]     disp_count,
  output logic              disp_ready,
  output logic              disp_slot,
  input  logic              out_valid,
  input  logic              out_slot,
  input  logic [RW-1:0]     out_reg,
  input  logic [DATA_W-1:0] out_data,
  input  logic              flush,
  input  logic [RW-1:0]     rd_reg,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              rf_we,
  output logic [RW-1:0]     rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  logic [1:0]        alloc, clear, wr_en, valid, done, hit;
  logic [CW-1:0]     expc   [SLOTS];
  logic [DATA_W-1:0] hdata  [SLOTS];
  logic [RW-1:0]     didx   [SLOTS];
  logic [DATA_W-1:0] ddata  [SLOTS];
  logic [EW-1:0]     dptr;
  slot_id_t          head, young;

  for (genvar s = 0; s < int'(SLOTS); s++) begin : g_slot
    bcu_slot #(.RW(RW), .DATA_W(DATA_W), .NENT(NENT)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc[s]),
      .alloc_cnt_i (disp_count),
      .clear_i     (clear[s]),
      .wr_en_i     (wr_en[s]),
      .wr_idx_i    (out_reg),
      .wr_data_i   (out_data),
      .look_idx_i  (rd_reg),
      .look_hit_o  (hit[s]),
      .look_data_o (hdata[s]),
      .drn_ptr_i   (dptr),
      .drn_idx_o   (didx[s]),
      .drn_data_o  (ddata[s]),
      .valid_o     (valid[s]),
      .done_o      (done[s]),
      .exp_o       (expc[s])
    );
  end

  bcu_ctrl #(.NENT(NENT)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid),
    .done_i       (done),
    .exp0_i       (expc[0]),
    .exp1_i       (expc[1]),
    .disp_v_i     (disp_valid),
    .wr_v_i       (out_valid),
    .wr_slot_i    (out_slot),
    .flush_i      (flush),
    .head_o       (head),
    .alloc_o      (alloc),
    .clear_o      (clear),
    .wr_en_o      (wr_en),
    .drn_ptr_o    (dptr),
    .rf_we_o      (rf_we),
    .disp_ready_o (disp_ready),
    .disp_slot_o  (disp_slot)
  );

  assign young    = other_slot(head);
  assign rf_waddr = didx[head];
  assign rf_wdata = ddata[head];

  // younger block shadows the older one, which shadows the register file
  always_comb begin
    if (hit[young]) begin
      rd_hit  = 1'b1;
      rd_data = hdata[young];
    end else if (hit[head]) begin
      rd_hit  = 1'b1;
      rd_data = hdata[head];
    end else begin
      rd_hit  = 1'b0;
      rd_data = rf_rdata;
    end
  end

  AST_DISP_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_count <= CW'(NENT)); // R10
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid == 2'b00) |-> !rf_we); // R5
endmodule

// File: tb/tb_blk_commit_unit.sv
`timescale 1ns/1ps
module tb_blk_commit_unit;
  localparam int NREG = 32, DW = 32, NENT = 16;
  localparam int RW = $clog2(NREG), CW = $clog2(NENT + 1);

  logic clk = 1'b0, rst_n;
  logic disp_valid, disp_ready, disp_slot;
  logic [CW-1:0] disp_count;
  logic out_valid, out_slot, flush;
  logic [RW-1:0] out_reg, rd_reg, rf_waddr;
  logic [DW-1:0] out_data, rf_rdata, rd_data, rf_wdata;
  logic rd_hit, rf_we;

  int checks = 0, errors = 0, cycles = 0;

  // reference state
  bit mv [2];
  int mexp [2], marr [2];
  int midx [2][NENT];
  int mdat [2][NENT];
  int mh, mdp;

  blk_commit_unit #(.NREG(NREG), .DATA_W(DW), .NENT(NENT)) dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_done(int s);
    return mv[s] && marr[s] == mexp[s];
  endfunction

  function automatic int m_tail();
    return mv[mh] ? 1 - mh : mh;
  endfunction

  task automatic m_look(input int r, input int rfd, output bit h, output int d);
    h = 0; d = rfd;
    for (int k = 0; k < 2; k++) begin
      int s = (k == 0) ? 1 - mh : mh;
      if (!h && mv[s]) begin
        for (int j = 0; j < marr[s]; j++)
          if (midx[s][j] == r) begin h = 1; d = mdat[s][j]; end
      end
    end
  endtask

  task automatic compare();
    bit eh; int ed; bit ewe;
    int t;
    t = m_tail();
    chk("R2 disp_ready", disp_ready, !mv[t]);
    if (!mv[t]) chk("R2 disp_slot", disp_slot, t);
    ewe = m_done(mh) && mexp[mh] != 0;
    chk("R5 rf_we", rf_we, ewe);
    if (ewe) begin
      chk("R5 rf_waddr", rf_waddr, midx[mh][mdp]);
      chk("R5 rf_wdata", rf_wdata, mdat[mh][mdp]);
    end
    m_look(rd_reg, rf_rdata, eh, ed);
    chk("R7 rd_hit", rd_hit, eh);
    chk("R7 rd_data", rd_data, ed);
  endtask

  task automatic m_update();
    bit hd, ret; int t, ws;
    hd  = m_done(mh);
    ret = hd && (mexp[mh] == 0 || mdp == mexp[mh] - 1);
    t   = m_tail();
    if (flush) begin
      if (hd) mv[1 - mh] = 0;
      else begin mv[0] = 0; mv[1] = 0; end
    end else begin
      ws = out_slot;
      if (out_valid && mv[ws] && !m_done(ws) && marr[ws] < mexp[ws]) begin
        midx[ws][marr[ws]] = out_reg;
        mdat[ws][marr[ws]] = out_data;
        marr[ws]++;
      end
      if (disp_valid && !mv[t]) begin
        mv[t] = 1; mexp[t] = disp_count; marr[t] = 0;
      end
    end
    if (ret) begin mv[mh] = 0; mdp = 0; mh = 1 - mh; end
    else if (hd) mdp++;
  endtask

  task automatic idle();
    disp_valid = 0; disp_count = '0; out_valid = 0; out_slot = 0;
    out_reg = '0; out_data = '0; flush = 0;
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    m_update();
    @(negedge clk);
    idle();
  endtask

  task automatic set_disp(int n);
    disp_valid = 1; disp_count = CW'(n);
  endtask

  task automatic set_wr(int s, int r, int d);
    out_valid = 1; out_slot = s[0]; out_reg = RW'(r); out_data = d;
  endtask

  task automatic peek(int r, int rfd);
    rd_reg = RW'(r); rf_rdata = rfd; #1;
  endtask

  initial begin
    int seed, s16, pulses; logic [DW-1:0] lastd;
    seed = $urandom(32'h5eed);
    idle(); rd_reg = '0; rf_rdata = '0;
    mv[0] = 0; mv[1] = 0; mh = 0; mdp = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R1 disp_ready", disp_ready, 1);
    chk("R1 disp_slot", disp_slot, 0);
    chk("R1 rf_we", rf_we, 0);
    chk("R1 rd_hit", rd_hit, 0);

    // ordering, forwarding, ignored writes
    set_disp(3); cyc();
    set_wr(0, 3, 'h11); cyc();
    set_wr(0, 3, 'h22); cyc();
    peek(3, 'h5); chk("R7 last write wins", rd_data, 'h22);
    set_wr(1, 5, 'h99); cyc();
    peek(5, 'h77); chk("R3 empty slot hit", rd_hit, 0); chk("R3 empty slot data", rd_data, 'h77);
    chk("R2 next slot", disp_slot, 1);
    set_disp(1); cyc();
    chk("R2 full", disp_ready, 0);
    set_wr(1, 3, 'h33); cyc();
    peek(3, 0); chk("R7 younger first", rd_data, 'h33);
    chk("R6 younger waits", rf_we, 0);
    set_wr(1, 3, 'h55); cyc();
    peek(3, 0); chk("R3 complete block", rd_data, 'h33);
    set_wr(0, 4, 'h44); cyc();
    chk("R5 first we", rf_we, 1); chk("R5 first addr", rf_waddr, 3); chk("R5 first data", rf_wdata, 'h11);
    cyc(); chk("R5 second data", rf_wdata, 'h22);
    cyc(); chk("R5 third addr", rf_waddr, 4); chk("R5 third data", rf_wdata, 'h44);
    cyc(); chk("R6 younger next", rf_we, 1); chk("R6 younger data", rf_wdata, 'h33);
    cyc(); chk("R6 idle", rf_we, 0);

    // flush with incomplete oldest
    set_disp(2); cyc();
    set_disp(1); cyc();
    set_wr(0, 6, 5); cyc();
    flush = 1; set_wr(1, 6, 9); cyc();
    chk("R8 ready", disp_ready, 1); chk("R8 slot", disp_slot, 0);
    peek(6, 0); chk("R8 gone", rd_hit, 0);

    // flush during drain
    set_disp(2); cyc();
    set_disp(1); cyc();
    set_wr(1, 7, 8); cyc();
    set_wr(0, 9, 'h12); cyc();
    set_wr(0, 10, 'h13); cyc();
    chk("R5 drain addr", rf_waddr, 9);
    flush = 1; cyc();
    chk("R9 drain kept", rf_we, 1); chk("R9 drain addr", rf_waddr, 10); chk("R9 drain data", rf_wdata, 'h13);
    cyc();
    chk("R9 done", rf_we, 0); chk("R9 ready", disp_ready, 1);
    peek(7, 0); chk("R9 younger gone", rd_hit, 0);

    // zero-count block
    set_disp(0); cyc();
    chk("R4 no write", rf_we, 0);
    cyc();
    chk("R4 freed ready", disp_ready, 1); chk("R4 freed slot", disp_slot, 0);
    set_disp(1); cyc();
    chk("R4 other free", disp_ready, 1); chk("R4 other slot", disp_slot, 1);
    set_wr(0, 1, 1); cyc();
    repeat (3) cyc();

    // full block
    s16 = disp_slot;
    set_disp(NENT); cyc();
    for (int i = 0; i < NENT; i++) begin set_wr(s16, i % 8, 'h100 + i); cyc(); end
    pulses = 0; lastd = '0;
    for (int i = 0; i < NENT + 4; i++) begin
      #1; if (rf_we) begin pulses++; lastd = rf_wdata; end
      cyc();
    end
    chk("R10 full count", pulses, NENT);
    chk("R10 last data", lastd, 'h100 + NENT - 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 4 == 0) set_disp(($urandom % 8 == 0) ? NENT : $urandom % 5);
      if ($urandom % 2 == 0) set_wr($urandom % 2, $urandom % 8, $urandom);
      if ($urandom % 40 == 0) flush = 1;
      rd_reg = RW'($urandom % 8); rf_rdata = $urandom;
      cyc();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule